// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers up to fifteen interrupt request lines, numbered 1 to 15, and reduces them to one 4-bit interrupt level for a processor core. Each line passes through a two-flop synchronizer and a per-line trigger detector. When its trigger condition occurs, the line's bit in a pending register is set. Pending requests that are not masked compete on fixed priority. The winning line number is loaded into a level latch, and the latch holds it until software releases it with an explicit write.

A 2-bit mode field chooses between two behaviours. In the first, the block is a pass-through that forwards an externally encoded 4-bit level unchanged. In the second, the block is the controller, and those same four level pins become raw request lines 12 to 15. A global output mask bit hides the latched level from the core without stopping the latch. Software can therefore poll the latch without a trap being raised. All configuration and status goes through a small word-wide register port with a combinational read.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset is synchronous and active low. After reset the mask register (address 1) reads 0x0000FFFF, and the mode (address 0), pending (address 2) and latch (address 4) registers all read 0.
- R2: When the mode field (address 0, bits 1:0) holds any value other than 01, core_level equals lvl_in in the same cycle and no pending bit is set.
- R3: When the mode field is 01, lvl_in bit k acts as raw request line 12+k, and req_lo bit n-1 acts as request line n for n from 1 to 11.
- R4: Line n's trigger mode sits in bits 2n+1:2n of the trigger register (address 5). The encodings are 00 high level, 01 low level, 10 rising edge and 11 falling edge. The trigger is evaluated on the input after a two-flop synchronizer, and a hit sets pending bit n.
- R5: A pending bit stays set until a write to the request-clear register (address 3) has a 1 in bit n. Writing 0 bits has no effect. If a trigger hit and a clear land on the same cycle, the hit wins.
- R6: Priority is fixed, with line 15 highest and line 1 lowest. A line whose mask bit n (address 1) is set is left out of the latch, but its bit still shows in the pending register.
- R7: The latch loads the winning level only while it holds 0. A nonzero level stays until a write to address 4 with bit 8 set. That write empties the latch, and the next level loads on the following cycle.
- R8: Clearing the pending bit of the currently latched line leaves the latched level unchanged.
- R9: While mask bit 0 is set in mode 01, core_level is 0. The latch still loads, and its level still reads back in bits 3:0 of address 4.
- R10: Reads return zero in unused bits. Address 3 and unmapped addresses read 0, and address 5 reads back the written trigger modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_lo | input | 11 | Raw request lines 1 to 11 (bit n-1 is line n) |
| lvl_in | input | 4 | External encoded level in bypass mode; raw lines 12 to 15 in controller mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| core_level | output | 4 | Interrupt level presented to the core, 0 meaning none |

## Verification
The assertions assume that the request lines are sampled only through the synchronizer. They also assume that register writes are single-cycle strobes with stable address and data. The bench changes every input one time unit after the rising edge, and it holds each write for exactly one edge. Edge-triggered lines are held for at least one full clock so that the first synchronizer flop captures them. A behavioural model runs beside the design and checks the level output and the read bus on every falling edge. Directed checks then pin down priority, the hold-until-release rule, same-cycle set-versus-clear, and the global mask.

// File: rtl/irq_ctrl_pkg.sv
// Package: shared register addresses, field positions and trigger encodings
// for the prioritized interrupt request controller.
package irq_ctrl_pkg;
    localparam int          DATA_W      = 32;
    localparam int          ADDR_W      = 3;
    localparam logic [2:0]  ADDR_MODE   = 3'd0;
    localparam logic [2:0]  ADDR_MASK   = 3'd1;
    localparam logic [2:0]  ADDR_PEND   = 3'd2;
    localparam logic [2:0]  ADDR_RCLR   = 3'd3;
    localparam logic [2:0]  ADDR_LATCH  = 3'd4;
    localparam logic [2:0]  ADDR_TRIG   = 3'd5;
    localparam int          RELEASE_BIT = 8;
    localparam logic [1:0]  MODE_ACTIVE = 2'b01;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;
endpackage

// File: rtl/irq_sync_trig.sv
// Module: synchronizes each raw request line through two flops and evaluates
// its configured trigger condition on the synchronized value.
// Assumes: trigger configuration is quasi-static; line numbering starts at 1.
module irq_sync_trig
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_LINES:1]       raw,
    input  logic [2*NUM_LINES+1:2]   trig_cfg,
    output logic [NUM_LINES:1]       hit
);
    logic [NUM_LINES:1] meta_q, sync_q, prev_q;

    // Purpose: two-flop synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    for (genvar i = 1; i <= NUM_LINES; i++) begin : g_line
        trig_e mode_i;
        assign mode_i = trig_e'(trig_cfg[2*i +: 2]);
        // Purpose: per-line trigger condition decode.
        always_comb begin
            unique case (mode_i)
                TRIG_HIGH: hit[i] = sync_q[i];
                TRIG_LOW:  hit[i] = ~sync_q[i];
                TRIG_RISE: hit[i] = sync_q[i] & ~prev_q[i];
                TRIG_FALL: hit[i] = ~sync_q[i] & prev_q[i];
                default:   hit[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/irq_pend_prio.sv
// Module: pending request register with per-bit clear, and a fixed-priority
// encoder over unmasked pending requests (highest line number wins).
// Assumes: clr is a one-cycle strobe vector; a hit in the same cycle wins.
module irq_pend_prio
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 15,
    parameter int LVL_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [NUM_LINES:1]   hit,
    input  logic [NUM_LINES:1]   clr,
    input  logic [NUM_LINES:1]   line_mask,
    output logic [NUM_LINES:1]   pend,
    output logic [LVL_W-1:0]     cand
);
    logic [NUM_LINES:1] live;

    // Purpose: capture trigger hits while enabled, drop bits written to clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | (hit & {NUM_LINES{en}});
    end

    assign live = pend & ~line_mask;

    // Purpose: fixed priority encode, later (higher) lines override.
    always_comb begin
        cand = '0;
        for (int i = 1; i <= NUM_LINES; i++) begin
            if (live[i]) cand = LVL_W'(i);
        end
    end

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ~clr)) |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr)));
endmodule

// File: rtl/irq_level_latch.sv
// Module: holds the encoded level; loads only when empty and enabled,
// empties on a software release strobe (release wins over a load).
// Assumes: release is a one-cycle strobe from the register port.
module irq_level_latch #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rel,
    input  logic [LVL_W-1:0] cand,
    output logic [LVL_W-1:0] level
);
    // Purpose: load-when-empty latch with explicit release.
    always_ff @(posedge clk) begin
        if (!rst_n)                    level <= '0;
        else if (rel)                  level <= '0;
        else if (en && level == '0)    level <= cand;
    end

    // R7
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0 && !rel) |=> (level == $past(level)));
    // R7
    latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> (level == '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Module: top of the prioritized interrupt request controller. Holds the
// mode, mask and trigger registers, maps pins to request lines, decodes the
// register port and selects between bypass and controller output.
// Assumes: single-cycle write strobes; reads are combinational.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 15,
    parameter int LVL_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINES-LVL_W-1:0]    req_lo,
    input  logic [LVL_W-1:0]              lvl_in,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [DATA_W-1:0]             reg_wdata,
    output logic [DATA_W-1:0]             reg_rdata,
    output logic [LVL_W-1:0]              core_level
);
    localparam int PIN_LINES = LVL_W;
    localparam int LOW_LINES = NUM_LINES - PIN_LINES;
    localparam int TRIG_TOP  = 2*NUM_LINES + 1;

    logic [1:0]           mode_q;
    logic [NUM_LINES:0]   mask_q;
    logic [TRIG_TOP:2]    trig_q;
    logic                 en;
    logic [NUM_LINES:1]   raw, hit, clr, pend;
    logic [LVL_W-1:0]     cand, level;
    logic                 rel;

    assign en = (mode_q == MODE_ACTIVE);

    // Purpose: map low request pins and (when enabled) level pins to lines.
    always_comb begin
        raw = '0;
        raw[LOW_LINES:1] = req_lo;
        if (en) raw[NUM_LINES:LOW_LINES+1] = lvl_in;
    end

    // Purpose: configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            mask_q <= '1;
            trig_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_MODE)  mode_q <= reg_wdata[1:0];
            if (reg_addr == ADDR_MASK)  mask_q <= reg_wdata[NUM_LINES:0];
            if (reg_addr == ADDR_TRIG)  trig_q <= reg_wdata[TRIG_TOP:2];
        end
    end

    assign clr = (reg_wr && reg_addr == ADDR_RCLR) ? reg_wdata[NUM_LINES:1] : '0;
    assign rel = reg_wr && (reg_addr == ADDR_LATCH) && reg_wdata[RELEASE_BIT];

    irq_sync_trig #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(raw), .trig_cfg(trig_q), .hit(hit));

    irq_pend_prio #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .en(en), .hit(hit), .clr(clr),
        .line_mask(mask_q[NUM_LINES:1]), .pend(pend), .cand(cand));

    irq_level_latch #(.LVL_W(LVL_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .en(en), .rel(rel), .cand(cand), .level(level));

    // Purpose: output select between bypass and masked latch.
    always_comb begin
        if (!en)            core_level = lvl_in;
        else if (mask_q[0]) core_level = '0;
        else                core_level = level;
    end

    // Purpose: combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_MODE:  reg_rdata[1:0]          = mode_q;
            ADDR_MASK:  reg_rdata[NUM_LINES:0]  = mask_q;
            ADDR_PEND:  reg_rdata[NUM_LINES:1]  = pend;
            ADDR_LATCH: reg_rdata[LVL_W-1:0]    = level;
            ADDR_TRIG:  reg_rdata[TRIG_TOP:2]   = trig_q;
            default:    reg_rdata               = '0;
        endcase
    end

    // R9
    out_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mask_q[0]) |-> (core_level == '0));
    // R2
    bypass_nocap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$isunknown(pend)) |=> ((pend & ~$past(pend)) == '0));
    // R8
    pclr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level != '0 && !rel && |clr) |=> (level == $past(level)));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module sim_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] req_lo = '0;
    logic [3:0]  lvl_in = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  core_level;

    int total = 0, bad = 0;
    string cur_req = "R1";
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u0 (.clk(clk), .rst_n(rst_n), .req_lo(req_lo), .lvl_in(lvl_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_level(core_level));

    // ---------------- reference model ----------------
    bit [15:0] m_s1, m_s2, m_pv, m_pend, m_mask;
    bit [31:0] m_trig;
    int        m_latch, m_mode;

    function automatic bit raw_bit(int n);
        if (n <= 11) return req_lo[n-1];
        return (m_mode == 1) ? lvl_in[n-12] : 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_pv = 0; m_pend = 0; m_mask = 16'hFFFF;
            m_trig = 0; m_latch = 0; m_mode = 0;
        end else begin
            bit [15:0] hit, clr, npend, ns1;
            int nl;
            bit en;
            en = (m_mode == 1);
            hit = 0;
            for (int n = 1; n <= 15; n++) begin
                case ((m_trig >> (2*n)) & 3)
                    0: hit[n] = m_s2[n];
                    1: hit[n] = !m_s2[n];
                    2: hit[n] = m_s2[n] && !m_pv[n];
                    default: hit[n] = !m_s2[n] && m_pv[n];
                endcase
            end
            clr = (reg_wr && reg_addr == 3) ? reg_wdata[15:0] : 16'h0;
            nl = m_latch;
            if (reg_wr && reg_addr == 4 && reg_wdata[8]) nl = 0;
            else if (en && m_latch == 0)
                for (int n = 1; n <= 15; n++) if (m_pend[n] && !m_mask[n]) nl = n;
            npend = (m_pend & ~clr) | (en ? hit : 16'h0);
            npend[0] = 0;
            ns1 = 0;
            for (int n = 1; n <= 15; n++) ns1[n] = raw_bit(n);
            m_pv = m_s2; m_s2 = m_s1; m_s1 = ns1;
            m_pend = npend; m_latch = nl;
            if (reg_wr) begin
                if (reg_addr == 0) m_mode = reg_wdata[1:0];
                if (reg_addr == 1) m_mask = reg_wdata[15:0];
                if (reg_addr == 5) m_trig = {reg_wdata[31:2], 2'b00};
            end
        end
    end

    function automatic logic [3:0] exp_level();
        if (m_mode != 1) return lvl_in;
        if (m_mask[0]) return 4'd0;
        return m_latch[3:0];
    endfunction

    function automatic logic [31:0] exp_read();
        case (reg_addr)
            3'd0: return 32'(m_mode);
            3'd1: return {16'h0, m_mask};
            3'd2: return {16'h0, m_pend};
            3'd4: return 32'(m_latch);
            3'd5: return m_trig;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_req, " level"}, 32'(core_level), 32'(exp_level()));
            chk({cur_req, " read"}, reg_rdata, exp_read());
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic rdchk(string req, logic [2:0] a, logic [31:0] exp);
        @(posedge clk); #1;
        reg_addr = a;
        #2;
        chk(req, reg_rdata, exp);
    endtask

    task automatic lvchk(string req, logic [3:0] exp);
        #0.5;
        chk(req, 32'(core_level), 32'(exp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        rdchk("R1 mask", 3'd1, 32'h0000FFFF);
        rdchk("R1 mode", 3'd0, 32'h0);
        rdchk("R1 pend", 3'd2, 32'h0);
        rdchk("R1 latch", 3'd4, 32'h0);
        // R2 bypass
        cur_req = "R2";
        lvl_in = 4'hA; req_lo = 11'h7FF;
        step(1); lvchk("R2 bypass", 4'hA);
        step(6);
        rdchk("R2 nocap", 3'd2, 32'h0);
        req_lo = 0; lvl_in = 0; step(4);
        // R3 enable controller, unmask all
        cur_req = "R3";
        wr(3'd0, 32'h1);
        wr(3'd1, 32'h0);
        req_lo[4] = 1; step(6);
        lvchk("R3 line5", 4'd5);
        cur_req = "R7";
        req_lo[8] = 1; step(6);
        lvchk("R7 hold", 4'd5);
        cur_req = "R8";
        req_lo[4] = 0; step(4);
        wr(3'd3, 32'h20); step(2);
        rdchk("R8 pend", 3'd2, 32'h200);
        lvchk("R8 latch kept", 4'd5);
        cur_req = "R7";
        wr(3'd4, 32'h100); step(3);
        lvchk("R7 next", 4'd9);
        // R6 priority
        cur_req = "R6";
        req_lo = 0; step(4);
        wr(3'd3, 32'hFFFE); wr(3'd4, 32'h100); step(3);
        lvchk("R6 idle", 4'd0);
        req_lo[2] = 1; req_lo[6] = 1; lvl_in = 4'b0100; step(6);
        lvchk("R3 R6 line14", 4'd14);
        rdchk("R6 pend", 3'd2, 32'h4088);
        wr(3'd1, 32'h4000); step(2);
        lvchk("R7 masked hold", 4'd14);
        wr(3'd4, 32'h100); step(3);
        lvchk("R6 masked skip", 4'd7);
        rdchk("R6 masked visible", 3'd2, 32'h4088);
        // R9 global mask
        cur_req = "R9";
        wr(3'd1, 32'h4001); step(1);
        lvchk("R9 hidden", 4'd0);
        rdchk("R9 latch read", 3'd4, 32'h7);
        wr(3'd1, 32'h4000); step(1);
        lvchk("R9 shown", 4'd7);
        // R4 triggers
        cur_req = "R4";
        req_lo = 0; lvl_in = 0; step(4);
        wr(3'd3, 32'hFFFE); wr(3'd4, 32'h100); step(3);
        rdchk("R4 clear", 3'd2, 32'h0);
        wr(3'd5, (32'd2 << 4) | (32'd3 << 12) | (32'd1 << 20));
        rdchk("R10 trig", 3'd5, 32'h0010_3020);
        step(4);
        rdchk("R4 low level", 3'd2, 32'h400);
        lvchk("R4 level10", 4'd10);
        req_lo[1] = 1; step(1); req_lo[1] = 0; step(5);
        rdchk("R4 rise", 3'd2, 32'h404);
        req_lo[5] = 1; step(5);
        rdchk("R4 no fall yet", 3'd2, 32'h404);
        req_lo[5] = 0; step(5);
        rdchk("R4 fall", 3'd2, 32'h444);
        // R5 clear semantics
        cur_req = "R5";
        wr(3'd3, 32'h400); step(2);
        rdchk("R5 hit wins", 3'd2, 32'h444);
        wr(3'd3, 32'h0); step(1);
        rdchk("R5 zero noop", 3'd2, 32'h444);
        wr(3'd3, 32'h4); step(1);
        rdchk("R5 clear bit2", 3'd2, 32'h440);
        rdchk("R10 rclr reads 0", 3'd3, 32'h0);
        rdchk("R10 unmapped", 3'd7, 32'h0);
        // R2 reserved mode acts as bypass
        cur_req = "R2";
        wr(3'd0, 32'h2);
        lvl_in = 4'b1011; step(1);
        lvchk("R2 mode10", 4'hB);
        wr(3'd3, 32'h400); step(3);
        rdchk("R2 no capture", 3'd2, 32'h040);
        step(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule